// File: doc/BRIEF.md
# BCD Calendar Clock Registers

This block keeps the time of day and the calendar date in seven byte-wide registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Every value is read in packed BCD. A host reaches the registers over a simple byte bus with separate read and write strobes and a three-bit register index. An external one-second strobe advances the time. The count carries through minutes, hours, date, month and year. Month lengths and leap years are applied.

Bit 7 of the seconds register is a run/halt control. While it is set, ticks are discarded and the time stays frozen. When it is cleared again, counting resumes from the frozen value. Writes that do not hold a legal BCD value for their field are dropped for that field. The weekday register also carries a century flag, which is stored as written. The calendar year that the two-digit year counts from is a parameter, `YEAR_BASE`. For example, 1968 makes the stored year equal the calendar year minus 1968. The leap-year rule is applied to the sum of the base and the stored year.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the registers read as follows. Seconds, minutes, hours and year read 0x00. Weekday, date and month read 0x01. The stop bit and the century flag read 0.
- R2: The register index is decoded as 0 = seconds, 1 = minutes, 2 = hours, 3 = weekday, 4 = date, 5 = month, 6 = year. Index 7 reads 0x00 and ignores writes. `rdata` takes the addressed value one clock after `rd_en` is sampled high. It holds its value while `rd_en` is low. All time fields are shown in BCD.
- R3: A seconds write always stores bit 7 as the stop bit. Bits 6:0 are loaded only when they form valid BCD (each nibble 0..9) in 0..59. A seconds read returns the stop bit in bit 7, ORed over the BCD seconds.
- R4: A minutes write uses bits 6:0 and takes effect only for valid BCD in 0..59. An hours write uses bits 5:0 and takes effect only for valid BCD in 0..23. Bits above the used field are ignored. Out-of-range values leave the register unchanged.
- R5: A weekday write always stores bit 6 as the century flag. It loads bits 2:0 as the weekday only when they are in 1..7. The weekday reads as {0, century, 000, weekday[2:0]}.
- R6: A date write uses bits 5:0 and takes effect only for valid BCD 1..31. A month write uses bits 4:0 and takes effect only for valid BCD 1..12. A year write uses all 8 bits and takes effect only for valid BCD 0..99.
- R7: While the stop bit is 1, ticks change no time field. After the stop bit is cleared, the next tick advances from the frozen value.
- R8: On a tick while running, seconds step up and roll from 59 to 0 with a carry. The carry ripples through minutes (59→0) and hours (23→0) into the date. The weekday advances with each date carry, cycling 1..7 (7→1).
- R9: The date rolls to 1 with a month carry after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months. February ends at 29 when (YEAR_BASE + year) is divisible by 4, and at 28 otherwise. Month 12 rolls to 1 with a year carry, and year 99 rolls to 00.
- R10: When a write and a running tick arrive in the same cycle, the written field takes the written value. The other fields advance as the tick dictates.
- R11: A date above the current month's length, which a write can set (31 in April, for example), rolls to 1 with a month carry on the next date carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the clock with `YEAR_BASE` = 1969. This setting moves the leap years off a multiple of four in the stored count: stored year 03 (1972) must give February 29, while stored years 00 and 04 must not. A design that tests the stored year alone would then fail. Directed scenarios cover the following:
- the full end-of-century ripple from 23:59:59 on December 31 of year 99;
- month-end rolls, including an over-long date written by software;
- halting and resuming the count;
- writes that coincide with a tick;
- rejected writes whose nibbles are not BCD and values that are out of range.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_AW = 3;
  localparam int DATA_W = 8;

  typedef enum logic [REG_AW-1:0] {
    IDX_SEC   = 3'd0,
    IDX_MIN   = 3'd1,
    IDX_HOUR  = 3'd2,
    IDX_WDAY  = 3'd3,
    IDX_DATE  = 3'd4,
    IDX_MON   = 3'd5,
    IDX_YEAR  = 3'd6,
    IDX_SPARE = 3'd7
  } reg_idx_e;

  // Binary time-of-day and calendar state
  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  // Per-field load strobes produced by the write decoder
  typedef struct packed {
    logic year;
    logic mon;
    logic date;
    logic wday;
    logic hour;
    logic min;
    logic sec;
  } ld_mask_t;

  function automatic logic bcd_digits_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // Tens digit by reciprocal multiply: exact for 0..99
  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [14:0] prod;
    logic [3:0]  tens;
    prod = 15'(v) * 15'd205;
    tens = prod[14:11];
    return {tens, 4'(v - 7'(tens) * 7'd10)};
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_pkg::*;
(
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ld_mask_t          ld,
  output tod_t              wval,
  output logic              stop_ld,
  output logic              stop_val,
  output logic              cent_ld,
  output logic              cent_val
);

  logic [7:0] f_sec, f_min, f_hour, f_date, f_mon, f_year;
  logic [6:0] b_sec, b_min, b_hour, b_date, b_mon, b_year;
  logic       hit_sec, hit_min, hit_hour, hit_wday, hit_date, hit_mon, hit_year;

  always_comb begin
    hit_sec  = wr_en && (addr == IDX_SEC);
    hit_min  = wr_en && (addr == IDX_MIN);
    hit_hour = wr_en && (addr == IDX_HOUR);
    hit_wday = wr_en && (addr == IDX_WDAY);
    hit_date = wr_en && (addr == IDX_DATE);
    hit_mon  = wr_en && (addr == IDX_MON);
    hit_year = wr_en && (addr == IDX_YEAR);

    // Field extraction: only the bits each register defines
    f_sec  = {1'b0, wdata[6:0]};
    f_min  = {1'b0, wdata[6:0]};
    f_hour = {2'b00, wdata[5:0]};
    f_date = {2'b00, wdata[5:0]};
    f_mon  = {3'b000, wdata[4:0]};
    f_year = wdata;

    b_sec  = bcd_to_bin(f_sec);
    b_min  = bcd_to_bin(f_min);
    b_hour = bcd_to_bin(f_hour);
    b_date = bcd_to_bin(f_date);
    b_mon  = bcd_to_bin(f_mon);
    b_year = bcd_to_bin(f_year);

    ld.sec  = hit_sec  && bcd_digits_ok(f_sec)  && (b_sec  <= 7'd59);
    ld.min  = hit_min  && bcd_digits_ok(f_min)  && (b_min  <= 7'd59);
    ld.hour = hit_hour && bcd_digits_ok(f_hour) && (b_hour <= 7'd23);
    ld.wday = hit_wday && (wdata[2:0] != 3'd0);
    ld.date = hit_date && bcd_digits_ok(f_date) && (b_date >= 7'd1) && (b_date <= 7'd31);
    ld.mon  = hit_mon  && bcd_digits_ok(f_mon)  && (b_mon  >= 7'd1) && (b_mon  <= 7'd12);
    ld.year = hit_year && bcd_digits_ok(f_year) && (b_year <= 7'd99);

    wval.sec  = b_sec[5:0];
    wval.min  = b_min[5:0];
    wval.hour = b_hour[4:0];
    wval.wday = wdata[2:0];
    wval.date = b_date[4:0];
    wval.mon  = b_mon[3:0];
    wval.year = b_year;

    stop_ld  = hit_sec;
    stop_val = wdata[7];
    cent_ld  = hit_wday;
    cent_val = wdata[6];
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int YEAR_BASE = 2000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  ld_mask_t ld,
  input  tod_t     wval,
  input  logic     stop_ld,
  input  logic     stop_val,
  input  logic     cent_ld,
  input  logic     cent_val,
  output tod_t     tod_q,
  output logic     stop_q,
  output logic     cent_q
);

  localparam logic [1:0] BASE_MOD4 = 2'(YEAR_BASE % 4);

  tod_t       nxt;
  logic       adv, leap;
  logic [4:0] dim;
  logic       c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    adv    = tick && !stop_q;
    leap   = (2'(tod_q.year[1:0] + BASE_MOD4) == 2'b00);
    dim    = days_in_month(tod_q.mon, leap);

    c_min  = adv    && (tod_q.sec  == 6'd59);
    c_hour = c_min  && (tod_q.min  == 6'd59);
    c_day  = c_hour && (tod_q.hour == 5'd23);
    c_mon  = c_day  && (tod_q.date >= dim);
    c_year = c_mon  && (tod_q.mon  == 4'd12);

    nxt = tod_q;
    if (adv)    nxt.sec  = c_min  ? 6'd0 : tod_q.sec + 6'd1;
    if (c_min)  nxt.min  = c_hour ? 6'd0 : tod_q.min + 6'd1;
    if (c_hour) nxt.hour = c_day  ? 5'd0 : tod_q.hour + 5'd1;
    if (c_day) begin
      nxt.date = c_mon ? 5'd1 : tod_q.date + 5'd1;
      nxt.wday = (tod_q.wday >= 3'd7) ? 3'd1 : tod_q.wday + 3'd1;
    end
    if (c_mon)  nxt.mon  = c_year ? 4'd1 : tod_q.mon + 4'd1;
    if (c_year) nxt.year = (tod_q.year == 7'd99) ? 7'd0 : tod_q.year + 7'd1;

    // Host writes override the tick result for their own field
    if (ld.sec)  nxt.sec  = wval.sec;
    if (ld.min)  nxt.min  = wval.min;
    if (ld.hour) nxt.hour = wval.hour;
    if (ld.wday) nxt.wday = wval.wday;
    if (ld.date) nxt.date = wval.date;
    if (ld.mon)  nxt.mon  = wval.mon;
    if (ld.year) nxt.year = wval.year;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q  <= '{year: 7'd0, mon: 4'd1, date: 5'd1, wday: 3'd1,
                  hour: 5'd0, min: 6'd0, sec: 6'd0};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
    end else begin
      tod_q <= nxt;
      if (stop_ld) stop_q <= stop_val;
      if (cent_ld) cent_q <= cent_val;
    end
  end

  // R7: a halted clock with no write keeps every field
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (stop_q && (ld == '0)) |=> $stable(tod_q));

  // R8: a running tick at 59 seconds wraps seconds
  p_sec_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop_q && !ld.sec && (tod_q.sec == 6'd59)) |=> (tod_q.sec == 6'd0));

  // R8: weekday wraps 7 -> 1 at the day boundary
  p_wday_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop_q && (ld == '0) && (tod_q.wday == 3'd7) && (tod_q.hour == 5'd23) &&
     (tod_q.min == 6'd59) && (tod_q.sec == 6'd59)) |=> (tod_q.wday == 3'd1));

  // R4 / R6: fields never leave their legal ranges
  p_fields_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (tod_q.sec <= 6'd59) && (tod_q.min <= 6'd59) && (tod_q.hour <= 5'd23) &&
    (tod_q.date != 5'd0) && (tod_q.mon >= 4'd1) && (tod_q.mon <= 4'd12) &&
    (tod_q.year <= 7'd99) && (tod_q.wday != 3'd0));

  // R10: a decoded write lands in the next cycle, tick or not
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ld.min |=> (tod_q.min == $past(wval.min)));

endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  tod_t              tod,
  input  logic              stop,
  input  logic              cent,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    case (reg_idx_e'(addr))
      IDX_SEC:  sel = bin_to_bcd({1'b0, tod.sec}) | {stop, 7'd0};
      IDX_MIN:  sel = bin_to_bcd({1'b0, tod.min});
      IDX_HOUR: sel = bin_to_bcd({2'b00, tod.hour});
      IDX_WDAY: sel = {1'b0, cent, 3'b000, tod.wday};
      IDX_DATE: sel = bin_to_bcd({2'b00, tod.date});
      IDX_MON:  sel = bin_to_bcd({3'b000, tod.mon});
      IDX_YEAR: sel = bin_to_bcd(tod.year);
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R2: read data holds between reads
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R2: the spare index always reads zero
  p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == IDX_SPARE)) |=> (rdata == '0));

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int YEAR_BASE = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  ld_mask_t ld;
  tod_t     wval, tod_q;
  logic     stop_ld, stop_val, cent_ld, cent_val, stop_q, cent_q;

  rtc_wr_decode u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ld       (ld),
    .wval     (wval),
    .stop_ld  (stop_ld),
    .stop_val (stop_val),
    .cent_ld  (cent_ld),
    .cent_val (cent_val)
  );

  rtc_time_core #(.YEAR_BASE(YEAR_BASE)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ld       (ld),
    .wval     (wval),
    .stop_ld  (stop_ld),
    .stop_val (stop_val),
    .cent_ld  (cent_ld),
    .cent_val (cent_val),
    .tod_q    (tod_q),
    .stop_q   (stop_q),
    .cent_q   (cent_q)
  );

  rtc_rd_mux u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .tod   (tod_q),
    .stop  (stop_q),
    .cent  (cent_q),
    .rdata (rdata)
  );

  // R3: a seconds write updates the stop bit in the next cycle
  p_stop_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == IDX_SEC)) |=> (stop_q == $past(wdata[7])));

endmodule

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_clock #(.YEAR_BASE(1969)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  localparam logic [2:0] A_S = 3'd0, A_M = 3'd1, A_H = 3'd2, A_W = 3'd3,
                         A_D = 3'd4, A_MO = 3'd5, A_Y = 3'd6, A_X = 3'd7;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, $sformatf("reg %0d", a), rdata, exp);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(A_H, h); wr(A_M, m); wr(A_S, s);
  endtask

  task automatic set_cal(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    wr(A_Y, y); wr(A_MO, mo); wr(A_D, d);
  endtask

  task automatic t_reset();
    expect_reg("R1", A_S, 8'h00);
    expect_reg("R1", A_M, 8'h00);
    expect_reg("R1", A_H, 8'h00);
    expect_reg("R1", A_W, 8'h01);
    expect_reg("R1", A_D, 8'h01);
    expect_reg("R1", A_MO, 8'h01);
    expect_reg("R1", A_Y, 8'h00);
  endtask

  task automatic t_decode();
    wr(A_X, 8'h55);
    expect_reg("R2", A_X, 8'h00);
    wr(A_S, 8'h09);
    pulse_tick();
    expect_reg("R2", A_S, 8'h10);
    // R2: rdata holds with rd_en low while another register changes
    wr(A_M, 8'h42);
    @(negedge clk);
    check("R2", "hold", rdata, 8'h10);
  endtask

  task automatic t_sec_write();
    wr(A_S, 8'h45);
    expect_reg("R3", A_S, 8'h45);
    wr(A_S, 8'h5A);
    expect_reg("R3", A_S, 8'h45);
    wr(A_S, 8'h60);
    expect_reg("R3", A_S, 8'h45);
  endtask

  task automatic t_min_hour();
    wr(A_M, 8'h59);
    expect_reg("R4", A_M, 8'h59);
    wr(A_M, 8'h60);
    expect_reg("R4", A_M, 8'h59);
    wr(A_H, 8'h23);
    wr(A_H, 8'h24);
    expect_reg("R4", A_H, 8'h23);
    wr(A_H, 8'hC8);
    expect_reg("R4", A_H, 8'h08);
  endtask

  task automatic t_wday();
    wr(A_W, 8'h45);
    expect_reg("R5", A_W, 8'h45);
    wr(A_W, 8'h08);
    expect_reg("R5", A_W, 8'h05);
  endtask

  task automatic t_cal_write();
    wr(A_D, 8'h31);
    wr(A_D, 8'h32);
    expect_reg("R6", A_D, 8'h31);
    wr(A_D, 8'h00);
    expect_reg("R6", A_D, 8'h31);
    wr(A_MO, 8'h12);
    wr(A_MO, 8'h13);
    expect_reg("R6", A_MO, 8'h12);
    wr(A_MO, 8'h00);
    expect_reg("R6", A_MO, 8'h12);
    wr(A_Y, 8'h99);
    wr(A_Y, 8'h9A);
    expect_reg("R6", A_Y, 8'h99);
  endtask

  task automatic t_century_roll();
    set_cal(8'h99, 8'h12, 8'h31);
    wr(A_W, 8'h07);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8", A_S, 8'h00);
    expect_reg("R8", A_M, 8'h00);
    expect_reg("R8", A_H, 8'h00);
    expect_reg("R8", A_W, 8'h01);
    expect_reg("R9", A_D, 8'h01);
    expect_reg("R9", A_MO, 8'h01);
    expect_reg("R9", A_Y, 8'h00);
  endtask

  task automatic t_leap();
    // stored 03 = 1972: leap
    set_cal(8'h03, 8'h02, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9", A_D, 8'h29);
    expect_reg("R9", A_MO, 8'h02);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9", A_D, 8'h01);
    expect_reg("R9", A_MO, 8'h03);
    // stored 04 = 1973 and 00 = 1969: not leap
    set_cal(8'h04, 8'h02, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9", A_MO, 8'h03);
    set_cal(8'h00, 8'h02, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9", A_D, 8'h01);
    set_cal(8'h10, 8'h04, 8'h30);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9", A_MO, 8'h05);
  endtask

  task automatic t_stop();
    wr(A_S, 8'h90);
    expect_reg("R3", A_S, 8'h90);
    pulse_tick(); pulse_tick(); pulse_tick();
    expect_reg("R7", A_S, 8'h90);
    wr(A_S, 8'h10);
    pulse_tick();
    expect_reg("R7", A_S, 8'h11);
    // clearing the stop bit with an illegal value keeps the frozen seconds
    wr(A_S, 8'hA0);
    wr(A_S, 8'h7F);
    pulse_tick();
    expect_reg("R7", A_S, 8'h21);
  endtask

  task automatic t_same_cycle();
    wr(A_S, 8'h11);
    wr(A_M, 8'h05);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = A_M; wdata = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg("R10", A_S, 8'h12);
    expect_reg("R10", A_M, 8'h30);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = A_S; wdata = 8'h59;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg("R10", A_S, 8'h59);
    expect_reg("R10", A_M, 8'h30);
    pulse_tick();
    expect_reg("R10", A_M, 8'h31);
  endtask

  task automatic t_overlong();
    set_cal(8'h20, 8'h04, 8'h31);
    set_time(8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R11", A_D, 8'h01);
    expect_reg("R11", A_MO, 8'h05);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_sec_write();
    t_min_hour();
    t_wday();
    t_cal_write();
    t_century_roll();
    t_leap();
    t_stop();
    t_same_cycle();
    t_overlong();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
    end
  end

endmodule